// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block gathers up to 32 interrupt sources into one request line for a parent interrupt controller. The block samples every source on each clock. A low-to-high transition on a source records an event in that source's pending bit, and the bit stays set until software acknowledges it. A per-source mask decides which pending bits can raise the parent line. In the mask, a 1 disables the source. Masking does not stop events from being recorded.

Software reaches the block through a flat register port made of an address, a write strobe with write data, and a read strobe with read data. The mask is never written as a whole word. One offset sets mask bits, a second offset clears them, and a third offset reads the mask back. Pending bits are read at one offset and removed by writing ones to another. Because every change is bitwise, the handler can acknowledge or mask one source without a read-modify-write.

Top module: `l2_irq_agg`

## Requirements
- R1: After reset the mask reads all ones (every source disabled), the pending register reads zero and `irq_o` is low.
- R2: A rising edge on `src_i[k]` sets pending bit k at the next clock edge, whether or not bit k is masked. A source held high does not set the bit again once it has been acknowledged.
- R3: The pending register is read at offset 0x00 and is read-only, so a write to 0x00 changes nothing.
- R4: Writing to offset 0x08 clears every pending bit whose write-data bit is 1 and leaves pending bits whose write-data bit is 0 unchanged.
- R5: When a new edge on source k and an acknowledge of bit k happen in the same clock cycle, pending bit k stays set.
- R6: Writing to offset 0x10 sets every mask bit whose write-data bit is 1, and write-data bits of 0 leave the mask unchanged.
- R7: Writing to offset 0x14 clears every mask bit whose write-data bit is 1, and write-data bits of 0 leave the mask unchanged.
- R8: Reading offset 0x0c returns the current mask.
- R9: `irq_o` is high exactly when at least one pending bit has a mask bit of 0, and it follows register changes in the same cycle.
- R10: A read of any offset other than 0x00, 0x0c, 0x10 and 0x14, or any cycle with `reg_re` low, returns zero on `reg_rdata`. Writes to unmapped offsets change no state. Offsets 0x10 and 0x14 read back the mask.
- R11: Writing all ones to 0x10 and then all ones to 0x08 leaves every source disabled, no bit pending and `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt source levels; rising edges are events |
| reg_addr | input | AW | Byte offset of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | NSRC | Write data |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | NSRC | Read data, combinational from address and read strobe |
| irq_o | output | 1 | Request line to the parent controller |

## Verification
A wrong pending bit shows up one cycle after the edge or write that caused it, both on a read of 0x00 and, when the source is unmasked, on `irq_o`. A wrong mask bit shows up immediately on a read of 0x0c. It also shows up on `irq_o` as soon as a pending bit exists for that source. An edge detector that retriggers on a level is exposed by acknowledging a source that is still held high and then reading the pending register again.

// File: rtl/l2_irq_agg.sv
module l2_irq_agg #(
  parameter int NSRC = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_we,
  input  logic [NSRC-1:0] reg_wdata,
  input  logic            reg_re,
  output logic [NSRC-1:0] reg_rdata,
  output logic            irq_o
);

  localparam logic [AW-1:0] OFS_PEND = AW'(8'h00);
  localparam logic [AW-1:0] OFS_ACK  = AW'(8'h08);
  localparam logic [AW-1:0] OFS_MASK = AW'(8'h0c);
  localparam logic [AW-1:0] OFS_MSET = AW'(8'h10);
  localparam logic [AW-1:0] OFS_MCLR = AW'(8'h14);

  logic [NSRC-1:0] src_q, pend_q, mask_q, rise, ack_bits;
  logic            wr_mset, wr_mclr;

  assign rise     = src_i & ~src_q;
  assign ack_bits = (reg_we && reg_addr == OFS_ACK) ? reg_wdata : '0;
  assign wr_mset  = reg_we && reg_addr == OFS_MSET;
  assign wr_mclr  = reg_we && reg_addr == OFS_MCLR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      src_q  <= src_i;
      pend_q <= (pend_q & ~ack_bits) | rise;
      if (wr_mset)      mask_q <= mask_q | reg_wdata;
      else if (wr_mclr) mask_q <= mask_q & ~reg_wdata;
    end
  end

  assign irq_o = |(pend_q & ~mask_q);

  always_comb begin
    reg_rdata = '0;
    if (reg_re) begin
      case (reg_addr)
        OFS_PEND:                     reg_rdata = pend_q;
        OFS_MASK, OFS_MSET, OFS_MCLR: reg_rdata = mask_q;
        default:                      reg_rdata = '0;
      endcase
    end
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    a_r2_rise_latch: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src_i[k]) |=> pend_q[k]);
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == OFS_ACK && reg_wdata[k] && !src_i[k]) |=> !pend_q[k]);
  end

  a_r6_mset_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_MSET) |=> ((mask_q & $past(reg_wdata)) == $past(reg_wdata)));
  a_r7_mclr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFS_MCLR) |=> ((mask_q & $past(reg_wdata)) == '0));
  a_r3_pend_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (rise == '0 && !(reg_we && reg_addr == OFS_ACK)) |=> $stable(pend_q));
  a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |-> reg_rdata == '0);

endmodule

// File: tb/l2_irq_agg_tb.sv
module l2_irq_agg_tb;
  localparam int NSRC = 32;
  localparam int AW   = 8;

  logic            clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_i = '0;
  logic [AW-1:0]   reg_addr = '0;
  logic            reg_we = 0, reg_re = 0;
  logic [NSRC-1:0] reg_wdata = '0;
  logic [NSRC-1:0] reg_rdata;
  logic            irq_o;
  int checks = 0, errors = 0;

  l2_irq_agg #(.NSRC(NSRC), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .irq_o(irq_o));

  always #5 clk = ~clk;

  // op: 0 write, 1 read and compare, 2 compare irq_o with data[0], 3 idle clock
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] src;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 8'h0c, 32'hFFFF_FFFF, 32'h0,   4'd1},  // R1
    '{2'd1, 8'h00, 32'h0,         32'h0,   4'd1},  // R1
    '{2'd2, 8'h00, 32'h0,         32'h0,   4'd1},  // R1
    '{2'd3, 8'h00, 32'h0,         32'h5,   4'd2},  // R2 edges on bits 0,2
    '{2'd1, 8'h00, 32'h5,         32'h5,   4'd2},  // R2 latched while masked
    '{2'd2, 8'h00, 32'h0,         32'h5,   4'd9},  // R9 all masked
    '{2'd0, 8'h14, 32'h1,         32'h5,   4'd7},  // R7
    '{2'd1, 8'h0c, 32'hFFFF_FFFE, 32'h5,   4'd8},  // R8
    '{2'd2, 8'h00, 32'h1,         32'h5,   4'd9},  // R9
    '{2'd0, 8'h08, 32'h4,         32'h5,   4'd4},  // R4
    '{2'd1, 8'h00, 32'h1,         32'h5,   4'd4},  // R4 zero bits untouched
    '{2'd2, 8'h00, 32'h1,         32'h5,   4'd9},  // R9
    '{2'd0, 8'h08, 32'h1,         32'h5,   4'd4},  // R4
    '{2'd3, 8'h00, 32'h0,         32'h5,   4'd2},  // R2 level held
    '{2'd1, 8'h00, 32'h0,         32'h5,   4'd2},  // R2 no retrigger
    '{2'd2, 8'h00, 32'h0,         32'h5,   4'd9},  // R9
    '{2'd3, 8'h00, 32'h0,         32'h0,   4'd2},  // R2
    '{2'd0, 8'h08, 32'h100,       32'h100, 4'd5},  // R5 edge and ack together
    '{2'd1, 8'h00, 32'h100,       32'h100, 4'd5},  // R5
    '{2'd0, 8'h00, 32'hFFFF_FFFF, 32'h100, 4'd3},  // R3
    '{2'd1, 8'h00, 32'h100,       32'h100, 4'd3},  // R3
    '{2'd0, 8'h04, 32'hFFFF_FFFF, 32'h100, 4'd10}, // R10
    '{2'd1, 8'h04, 32'h0,         32'h100, 4'd10}, // R10
    '{2'd1, 8'h0c, 32'hFFFF_FFFE, 32'h100, 4'd10}, // R10
    '{2'd1, 8'h00, 32'h100,       32'h100, 4'd10}, // R10
    '{2'd0, 8'h10, 32'h0,         32'h100, 4'd6},  // R6
    '{2'd1, 8'h0c, 32'hFFFF_FFFE, 32'h100, 4'd6},  // R6
    '{2'd0, 8'h14, 32'h100,       32'h100, 4'd7},  // R7
    '{2'd1, 8'h10, 32'hFFFF_FEFE, 32'h100, 4'd7},  // R7 via mask-set offset read
    '{2'd2, 8'h00, 32'h1,         32'h100, 4'd9},  // R9
    '{2'd0, 8'h10, 32'h1,         32'h100, 4'd6},  // R6
    '{2'd1, 8'h0c, 32'hFFFF_FEFF, 32'h100, 4'd6},  // R6
    '{2'd0, 8'h14, 32'h0,         32'h100, 4'd7},  // R7
    '{2'd1, 8'h14, 32'hFFFF_FEFF, 32'h100, 4'd7},  // R7
    '{2'd0, 8'h10, 32'hFFFF_FFFF, 32'h100, 4'd11}, // R11
    '{2'd0, 8'h08, 32'hFFFF_FFFF, 32'h100, 4'd11}, // R11
    '{2'd1, 8'h0c, 32'hFFFF_FFFF, 32'h100, 4'd11}, // R11
    '{2'd1, 8'h00, 32'h0,         32'h100, 4'd11}  // R11
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0; reg_wdata = '0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input int req);
    reg_addr = a; reg_re = 1;
    #1 check(reg_rdata, exp, req);
    reg_re = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      src_i = VEC[i].src;
      case (VEC[i].op)
        2'd0: wr(VEC[i].addr, VEC[i].data);
        2'd1: rd_check(VEC[i].addr, VEC[i].data, int'(VEC[i].req));
        2'd2: begin #1 check({31'b0, irq_o}, {31'b0, VEC[i].data[0]}, int'(VEC[i].req)); end
        default: @(negedge clk);
      endcase
    end
    check({31'b0, irq_o}, 32'h0, 11); // R11 line low

    // R10: read strobe low returns zero even at a mapped offset
    reg_addr = 8'h0c; reg_re = 0;
    #1 check(reg_rdata, 32'h0, 10);

    // R1: reset in the middle of activity
    wr(8'h14, 32'hFFFF_FFFF);
    src_i = 32'h0; @(negedge clk);
    src_i = 32'h8000_0000; @(negedge clk);
    #1 check({31'b0, irq_o}, 32'h1, 9); // R9
    rst_n = 0; #1;
    check({31'b0, irq_o}, 32'h0, 1);
    rd_check(8'h0c, 32'hFFFF_FFFF, 1);
    rd_check(8'h00, 32'h0, 1);
    src_i = 32'h0;
    @(negedge clk); rst_n = 1; @(negedge clk);

    // R2 + R9: edge on a masked high bit, then unmask
    src_i = 32'h8000_0000; @(negedge clk);
    rd_check(8'h00, 32'h8000_0000, 2);
    wr(8'h14, 32'h8000_0000);
    #1 check({31'b0, irq_o}, 32'h1, 9);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule